// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This unit repairs an 8-bit accumulator after a binary add or subtract whose operands were packed two-digit BCD values. Along with the raw sum or difference, it receives the three flags the arithmetic step left behind: the subtract marker N, the half-carry H and the carry C. It adds a per-digit correction so that the accumulator again holds two valid decimal digits. It also produces a fresh flag set: carry, zero, sign, parity, half-carry and the unchanged N.

Operation is strobed. A one-cycle `start` pulse samples the operands. On the next clock edge the corrected value and flags appear in output registers, and `out_valid` is high for exactly that cycle. The outputs hold their value until the next strobe.

A small two-state sequencer tracks this. It has two states:
- `ST_IDLE`: no result is being presented.
- `ST_EMIT`: a fresh result is on the outputs.

It has three transitions:
- `go`: `ST_IDLE` to `ST_EMIT` when `start` is high.
- `again`: `ST_EMIT` to `ST_EMIT` when `start` is high.
- `rest`: `ST_EMIT` to `ST_IDLE` when `start` is low.

Top module: `dadj_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `acc_out` and every flag output are 0.
- R2: With N=0, 06h is added to the accumulator when its low nibble exceeds 9 or H=1.
- R3: With N=0, 60h is added when the accumulator exceeds 99h or C=1. The carry output equals that condition. When both the R2 and R3 conditions hold, the correction is 66h.
- R4: With N=1, the low-digit condition (H=1 or low nibble above 9) adds FAh, and the high-digit condition (C=1 or accumulator above 99h) adds A0h. When both conditions hold, 9Ah is added. The carry output equals the high-digit condition.
- R5: With N=0, H=0 and C=0, and both nibbles in 0–9, the accumulator passes unchanged and the carry output is 0.
- R6: `s_out` is bit 7 of the result. `z_out` is 1 when the result is 00h. `p_out` is 1 when the result has an even number of set bits.
- R7: With N=0, `h_out` is 1 when the input low nibble exceeds 9. With N=1, `h_out` is 1 when H=1 and the input low nibble is below 6. `n_out` equals the N input.
- R8: The result and flags register on the first rising edge after `start` is sampled high. `out_valid` is high for the following cycle only. Back-to-back strobes give one result per cycle.
- R9: In a cycle where `start` is low, `out_valid` falls or stays low, and `acc_out` and all flags keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sample operands and begin an adjust |
| acc_in | input | 8 | Accumulator after the binary add/subtract |
| n_in | input | 1 | Subtract marker from the arithmetic step |
| h_in | input | 1 | Half-carry from the arithmetic step |
| c_in | input | 1 | Carry from the arithmetic step |
| out_valid | output | 1 | Result present this cycle |
| acc_out | output | 8 | Decimal-corrected accumulator |
| c_out | output | 1 | Decimal carry/borrow |
| z_out | output | 1 | Result is zero |
| s_out | output | 1 | Result bit 7 |
| p_out | output | 1 | Even parity of result |
| h_out | output | 1 | Half-carry after adjust |
| n_out | output | 1 | Subtract marker, passed through |

## Verification
The bound checker watches the following on every clock:
- strobe-to-valid timing and holding of outputs between strobes;
- carry forcing by an incoming C;
- the no-correction case;
- pass-through of N;
- consistency of the sign, zero and parity flags with the registered value.

The actual correction amounts for all nibble ranges, and both half-carry rules, come only from the bench. The bench sweeps every accumulator value under every N/H/C combination against its own arithmetic model, with idle gaps that show the hold behaviour.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
    localparam int DATA_W    = 8;
    localparam int NIB_W     = DATA_W / 2;
    localparam int DIGIT_MAX = 9;
    localparam int LO_FIX    = 6;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic p;
        logic h;
        logic n;
    } dadj_flags_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } dadj_state_t;
endpackage

// File: rtl/dadj_detect.sv
module dadj_detect
    import dadj_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  logic              h,
    input  logic              c,
    output logic              lo_fix,
    output logic              hi_fix,
    output logic              lo_big
);
    logic [NIB_W-1:0] lo_nib;
    logic [NIB_W-1:0] hi_nib;
    logic             hi_big;

    always_comb begin
        lo_nib = acc[NIB_W-1:0];
        hi_nib = acc[DATA_W-1:NIB_W];
        lo_big = (lo_nib > NIB_W'(DIGIT_MAX));
        // value above 99h: high digit past 9, or high digit exactly 9 with low past 9
        hi_big = (hi_nib > NIB_W'(DIGIT_MAX)) ||
                 ((hi_nib == NIB_W'(DIGIT_MAX)) && lo_big);
        lo_fix = lo_big | h;
        hi_fix = hi_big | c;
    end
endmodule

// File: rtl/dadj_apply.sv
module dadj_apply
    import dadj_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  logic              n,
    input  logic              lo_fix,
    input  logic              hi_fix,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] corr;

    always_comb begin
        corr = '0;
        if (lo_fix) corr[NIB_W-1:0]      = NIB_W'(LO_FIX);
        if (hi_fix) corr[DATA_W-1:NIB_W] = NIB_W'(LO_FIX);
        // subtracting corr equals adding FA/A0/9A modulo 256
        result = n ? (acc - corr) : (acc + corr);
    end
endmodule

// File: rtl/dadj_flags.sv
module dadj_flags
    import dadj_pkg::*;
(
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] result,
    input  logic              n,
    input  logic              h,
    input  logic              hi_fix,
    input  logic              lo_big,
    output dadj_flags_t       flags
);
    logic lo_small;

    always_comb begin
        lo_small = (acc[NIB_W-1:0] < NIB_W'(LO_FIX));
        flags.c  = hi_fix;
        flags.z  = (result == '0);
        flags.s  = result[DATA_W-1];
        flags.p  = ~(^result);
        flags.h  = n ? (h & lo_small) : lo_big;
        flags.n  = n;
    end
endmodule

// File: rtl/dadj_unit.sv
module dadj_unit
    import dadj_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              n_in,
    input  logic              h_in,
    input  logic              c_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] acc_out,
    output logic              c_out,
    output logic              z_out,
    output logic              s_out,
    output logic              p_out,
    output logic              h_out,
    output logic              n_out
);
    dadj_state_t       state_q, state_d;
    logic              lo_fix, hi_fix, lo_big;
    logic [DATA_W-1:0] result;
    dadj_flags_t       flags_d, flags_q;
    logic [DATA_W-1:0] acc_q;

    dadj_detect u_detect (
        .acc    (acc_in),
        .h      (h_in),
        .c      (c_in),
        .lo_fix (lo_fix),
        .hi_fix (hi_fix),
        .lo_big (lo_big)
    );

    dadj_apply u_apply (
        .acc    (acc_in),
        .n      (n_in),
        .lo_fix (lo_fix),
        .hi_fix (hi_fix),
        .result (result)
    );

    dadj_flags u_flags (
        .acc    (acc_in),
        .result (result),
        .n      (n_in),
        .h      (h_in),
        .hi_fix (hi_fix),
        .lo_big (lo_big),
        .flags  (flags_d)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_EMIT;   // go
            ST_EMIT: state_d = start ? ST_EMIT       // again
                                     : ST_IDLE;      // rest
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            flags_q <= '0;
        end else if (start) begin
            acc_q   <= result;
            flags_q <= flags_d;
        end
    end

    assign out_valid = (state_q == ST_EMIT);
    assign acc_out   = acc_q;
    assign c_out     = flags_q.c;
    assign z_out     = flags_q.z;
    assign s_out     = flags_q.s;
    assign p_out     = flags_q.p;
    assign h_out     = flags_q.h;
    assign n_out     = flags_q.n;
endmodule

// File: rtl/dadj_unit_chk.sv
module dadj_unit_chk
    import dadj_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] acc_in,
    input logic              n_in,
    input logic              h_in,
    input logic              c_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] acc_out,
    input logic              c_out,
    input logic              z_out,
    input logic              s_out,
    input logic              p_out,
    input logic              h_out,
    input logic              n_out
);
    a_r8_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> out_valid);

    a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !out_valid);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(acc_out) && $stable(c_out) && $stable(h_out) && $stable(n_out)));

    a_r3_carry_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !n_in && c_in) |=> c_out);

    a_r4_borrow_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (start && n_in && c_in) |=> c_out);

    a_r5_no_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !n_in && !h_in && !c_in && (acc_in[3:0] <= 4'd9) && (acc_in[7:4] <= 4'd9))
        |=> (acc_out == $past(acc_in) && !c_out));

    a_r7_n_pass: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (n_out == $past(n_in)));

    a_r6_flag_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (s_out == acc_out[DATA_W-1] && z_out == (acc_out == '0) &&
                       p_out == ~(^acc_out)));

    always_comb begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (!out_valid && acc_out == '0 && !c_out && !z_out &&
                                      !s_out && !p_out && !h_out && !n_out);
        end
    end
endmodule

bind dadj_unit dadj_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
    .n_in(n_in), .h_in(h_in), .c_in(c_in), .out_valid(out_valid),
    .acc_out(acc_out), .c_out(c_out), .z_out(z_out), .s_out(s_out),
    .p_out(p_out), .h_out(h_out), .n_out(n_out)
);

// File: tb/tb_dadj_unit.sv
module tb_dadj_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic       n_in = 1'b0, h_in = 1'b0, c_in = 1'b0;
    logic       out_valid;
    logic [7:0] acc_out;
    logic       c_out, z_out, s_out, p_out, h_out, n_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state: what the outputs must show after the next edge
    bit       e_valid = 0;
    int       e_acc = 0;
    bit       e_c = 0, e_z = 0, e_s = 0, e_p = 0, e_h = 0, e_n = 0;
    bit       e_add = 1;

    always #4 clk = ~clk;

    dadj_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .acc_in(acc_in),
        .n_in(n_in), .h_in(h_in), .c_in(c_in), .out_valid(out_valid),
        .acc_out(acc_out), .c_out(c_out), .z_out(z_out), .s_out(s_out),
        .p_out(p_out), .h_out(h_out), .n_out(n_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // decimal-arithmetic model of the requirements
    task automatic model(input int a, input bit n, input bit h, input bit c);
        int lo, corr, r, ones;
        lo   = a % 16;
        corr = 0;
        if (lo > 9 || h)    corr += 6;
        if (a > 153 || c)   corr += 96;
        r    = n ? (a - corr + 256) % 256 : (a + corr) % 256;
        e_acc = r;
        e_c   = (a > 153 || c);
        e_z   = (r == 0);
        e_s   = (r >= 128);
        ones  = 0;
        for (int b = 0; b < 8; b++) ones += (r >> b) & 1;
        e_p   = (ones % 2 == 0);
        e_h   = n ? (h && lo < 6) : (lo > 9);
        e_n   = n;
        e_add = !n;
    endtask

    task automatic compare_all();
        check("R8", out_valid, e_valid);
        if (e_add && !e_c && e_acc == e_acc) check(e_add ? "R2/R3/R5" : "R4", acc_out, e_acc);
        else check(e_add ? "R3" : "R4", acc_out, e_acc);
        check(e_add ? "R3" : "R4", c_out, e_c);
        check("R6", {z_out, s_out, p_out}, {e_z, e_s, e_p});
        check("R7", {h_out, n_out}, {e_h, e_n});
    endtask

    // one cycle: check at falling edge, then drive and advance model
    task automatic step(input bit st, input int a, input bit n, input bit h, input bit c);
        @(negedge clk);
        compare_all();
        start  = st;
        acc_in = a[7:0];
        n_in   = n; h_in = h; c_in = c;
        if (st) begin
            model(a, n, h, c);
            e_valid = 1;
        end else begin
            e_valid = 0; // R9: hold, previous expectations stay
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", {out_valid, acc_out, c_out, z_out, s_out, p_out, h_out, n_out}, 0);
        rst_n = 1'b1;

        // directed corner cases
        step(1, 8'h45, 0, 0, 0);   // R5 unchanged
        step(1, 8'h9A, 0, 0, 0);   // R3 66h, carry
        step(1, 8'h8B, 0, 0, 0);   // R2 06h only
        step(1, 8'h02, 0, 1, 0);   // R2 via H
        step(1, 8'h12, 0, 0, 1);   // R3 via C
        step(0, 8'hFF, 1, 1, 1);   // R9 ignored inputs
        step(0, 8'h00, 0, 0, 0);
        step(1, 8'h0F, 1, 1, 0);   // R4 FAh
        step(1, 8'h80, 1, 0, 1);   // R4 A0h
        step(1, 8'h66, 1, 1, 1);   // R4 9Ah
        step(1, 8'h9A, 0, 0, 0);   // R6 zero result
        step(0, 8'h00, 0, 0, 0);

        // sweep every accumulator value under every flag combination
        for (int f = 0; f < 8; f++) begin
            for (int a = 0; a < 256; a++) begin
                step(1, a, f[2], f[1], f[0]);
                if (a % 7 == 3) step(0, 255 - a, ~f[2], ~f[1], ~f[0]);
            end
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        compare_all();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8: watchdog expired, actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule